// File: doc/BRIEF.md
# ADC Result Threshold Monitor

This block watches the stream of finished conversion results from an analog-to-digital converter. A configuration word selects one input channel, a 10-bit threshold and a direction: "below the threshold" or "at or above the threshold". Each result from the selected channel is tested against that threshold. A run of qualifying results is counted. Once the run is long enough, a sticky alert flag is raised and, if enabled, an interrupt request.

Software loads the configuration word through a write strobe. It clears the alert by pulsing a write-one-to-clear input. Two independent monitors are made by placing two instances side by side, both fed from the same result stream.

Top module: `adc_cmp_monitor`

## Requirements
- R1: After a synchronous reset, `cmp_flag` and `cmp_irq` are 0, the run counter is 0 and the held configuration is all zeros, so the monitor is disabled.
- R2: A configuration write (`cfg_we`=1) loads `cfg_wdata` with this layout: bit 0 is the monitor enable and bit 1 is the interrupt enable. Bit 2 is the direction (0 = below, 1 = at or above). Bits [5:3] give the watched channel, bits [11:8] the run length N and bits [25:16] the threshold. The other bits are ignored.
- R3: A result is tested only in a cycle with all of these: the monitor is enabled, `res_valid` is 1, `res_chan` equals the watched channel, and no configuration write is taking place. Results that are not tested leave the counter and the flag unchanged.
- R4: With direction 0 a tested result qualifies when it is strictly less than the threshold. With direction 1 it qualifies when it is greater than or equal to the threshold.
- R5: Each qualifying result adds one to the run counter. The result that brings the run to N+1 sets `cmp_flag` at that clock edge and returns the counter to 0. For N=0 a single qualifying result is enough, and N can be as large as 15.
- R6: A tested result that does not qualify returns the run counter to 0, so only consecutive qualifying results on the watched channel make up a run.
- R7: A configuration write, or any cycle in which the monitor is disabled, returns the run counter to 0.
- R8: `cmp_flag` stays at 1 until a cycle with `flag_clr`=1. A configuration write does not clear it. If the flag is set and cleared in the same cycle, the set wins.
- R9: `cmp_irq` is registered and equals `cmp_flag` AND the interrupt enable after every edge. It follows a change of the interrupt enable made by a configuration write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| flag_clr | input | 1 | Write-one-to-clear pulse for the alert flag |
| res_valid | input | 1 | A conversion result is presented this cycle |
| res_chan | input | 3 | Channel of the presented result |
| res_data | input | 10 | Presented conversion result |
| cmp_flag | output | 1 | Sticky alert flag |
| cmp_irq | output | 1 | Interrupt request |

## Verification
The bound checker checks these on every cycle:
- the counter never passes the programmed run length;
- the counter returns to zero after a configuration write, a disabled cycle or a non-qualifying tested result;
- a completed run always leaves the flag set, even when a clear arrives in the same cycle;
- the flag only rises on a tested result and stays up without a clear;
- the interrupt is never active without the flag.

Only the bench's scenarios show the rest: that the configuration word is decoded correctly, the exact threshold boundary for each direction, that results on other channels are really ignored, the longest run length, and that an interrupt-enable rewrite reaches the interrupt output.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
  // Bit positions inside the configuration word
  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_IE      = 1;
  localparam int unsigned BIT_DIR     = 2;
  localparam int unsigned CH_LSB      = 3;
  localparam int unsigned RUN_LSB     = 8;
  localparam int unsigned THR_LSB     = 16;

  typedef enum logic {
    DIR_BELOW   = 1'b0,
    DIR_AT_OVER = 1'b1
  } dir_e;
endpackage

// File: rtl/cmp_cfg_reg.sv
module cmp_cfg_reg #(
  parameter int unsigned CFG_W  = 32,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned RUN_W  = 4,
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_W-1:0]  wdata,
  output logic              en,
  output logic              ie,
  output adc_cmp_pkg::dir_e dir,
  output logic [CH_W-1:0]   ch,
  output logic [RUN_W-1:0]  run_len,
  output logic [DATA_W-1:0] thr
);
  import adc_cmp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      ie      <= 1'b0;
      dir     <= DIR_BELOW;
      ch      <= '0;
      run_len <= '0;
      thr     <= '0;
    end else if (we) begin
      en      <= wdata[BIT_EN];
      ie      <= wdata[BIT_IE];
      dir     <= dir_e'(wdata[BIT_DIR]);
      ch      <= wdata[CH_LSB +: CH_W];
      run_len <= wdata[RUN_LSB +: RUN_W];
      thr     <= wdata[THR_LSB +: DATA_W];
    end
  end
endmodule

// File: rtl/cmp_match_eval.sv
module cmp_match_eval #(
  parameter int unsigned CH_W   = 3,
  parameter int unsigned DATA_W = 10
) (
  input  logic              en,
  input  adc_cmp_pkg::dir_e dir,
  input  logic [CH_W-1:0]   ch,
  input  logic [DATA_W-1:0] thr,
  input  logic              blocked,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  output logic              tested,
  output logic              qualifies
);
  import adc_cmp_pkg::*;

  logic below;

  always_comb begin
    tested    = en && res_valid && !blocked && (res_chan == ch);
    below     = (res_data < thr);
    qualifies = (dir == DIR_BELOW) ? below : !below;
  end
endmodule

// File: rtl/cmp_run_counter.sv
module cmp_run_counter #(
  parameter int unsigned RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tested,
  input  logic             qualifies,
  input  logic [RUN_W-1:0] run_len,
  output logic             done,
  output logic [RUN_W-1:0] cnt
);
  logic [RUN_W-1:0] cnt_q;

  assign done = tested && qualifies && (cnt_q == run_len);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tested) begin
      if (!qualifies || done) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_cmp_monitor.sv
module adc_cmp_monitor #(
  parameter int unsigned CFG_W  = 32,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned RUN_W  = 4,
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              flag_clr,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  output logic              cmp_flag,
  output logic              cmp_irq
);
  import adc_cmp_pkg::*;

  logic              en_q, ie_q;
  dir_e              dir_q;
  logic [CH_W-1:0]   ch_q;
  logic [RUN_W-1:0]  run_len_q;
  logic [DATA_W-1:0] thr_q;
  logic              tested, qualifies, done;
  logic [RUN_W-1:0]  cnt;
  logic              flag_d, ie_d;

  cmp_cfg_reg #(.CFG_W(CFG_W), .CH_W(CH_W), .RUN_W(RUN_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .en(en_q), .ie(ie_q), .dir(dir_q), .ch(ch_q), .run_len(run_len_q), .thr(thr_q)
  );

  cmp_match_eval #(.CH_W(CH_W), .DATA_W(DATA_W)) u_eval (
    .en(en_q), .dir(dir_q), .ch(ch_q), .thr(thr_q), .blocked(cfg_we),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .tested(tested), .qualifies(qualifies)
  );

  cmp_run_counter #(.RUN_W(RUN_W)) u_run (
    .clk(clk), .rst(rst), .restart(cfg_we || !en_q),
    .tested(tested), .qualifies(qualifies), .run_len(run_len_q),
    .done(done), .cnt(cnt)
  );

  always_comb begin
    flag_d = done ? 1'b1 : (flag_clr ? 1'b0 : cmp_flag);
    ie_d   = cfg_we ? cfg_wdata[BIT_IE] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_flag <= 1'b0;
      cmp_irq  <= 1'b0;
    end else begin
      cmp_flag <= flag_d;
      cmp_irq  <= flag_d && ie_d;
    end
  end
endmodule

// File: rtl/adc_cmp_checker.sv
module adc_cmp_checker #(
  parameter int unsigned RUN_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             flag_clr,
  input logic             en,
  input logic             tested,
  input logic             qualifies,
  input logic [RUN_W-1:0] cnt,
  input logic [RUN_W-1:0] run_len,
  input logic             cmp_flag,
  input logic             cmp_irq
);
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst) cmp_irq |-> cmp_flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (cmp_flag && !flag_clr) |=> cmp_flag); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst) (tested && qualifies && cnt == run_len) |=> cmp_flag); // R5
  AST_RISE_NEEDS_TEST: assert property (@(posedge clk) disable iff (rst) (!cmp_flag && !tested) |=> !cmp_flag); // R3
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= run_len); // R5
  AST_CNT_ZERO_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) cfg_we |=> (cnt == '0)); // R7
  AST_CNT_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) !en |=> (cnt == '0)); // R7
  AST_MISS_RESTARTS: assert property (@(posedge clk) disable iff (rst) (tested && !qualifies) |=> (cnt == '0)); // R6
endmodule

bind adc_cmp_monitor adc_cmp_checker #(.RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .flag_clr(flag_clr), .en(en_q),
  .tested(tested), .qualifies(qualifies), .cnt(cnt), .run_len(run_len_q),
  .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
);

// File: tb/tb_adc_cmp_monitor.sv
module tb_adc_cmp_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        flag_clr = 1'b0;
  logic        res_valid = 1'b0;
  logic [2:0]  res_chan = '0;
  logic [9:0]  res_data = '0;
  logic        cmp_flag, cmp_irq;
  int          n_checks = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  adc_cmp_monitor dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .flag_clr(flag_clr),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
  );

  function automatic logic [31:0] mk(input logic en, input logic ie, input logic dir,
                                     input logic [2:0] ch, input logic [3:0] n, input logic [9:0] thr);
    return {6'b0, thr, 4'b0, n, 2'b0, ch, dir, ie, en};
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic push(input logic [2:0] ch, input logic [9:0] d, input logic clr);
    @(negedge clk); res_valid = 1'b1; res_chan = ch; res_data = d; flag_clr = clr;
    @(negedge clk); res_valid = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "flag after reset", cmp_flag, 1'b0);
    check("R1", "irq after reset", cmp_irq, 1'b0);
    push(3'd0, 10'd0, 1'b0);  // config is zero: disabled, nothing happens
    check("R1", "flag while disabled by reset", cmp_flag, 1'b0);
  endtask

  task automatic t_below();
    wr_cfg(mk(1, 1, 0, 3'd2, 4'd2, 10'd100));
    push(3'd2, 10'd50, 0);
    push(3'd2, 10'd99, 0);
    check("R4", "two of three below", cmp_flag, 1'b0);
    push(3'd2, 10'd10, 0);
    check("R2", "third below sets flag", cmp_flag, 1'b1);
    check("R9", "irq with ie", cmp_irq, 1'b1);
    clear_flag();
    check("R8", "flag cleared", cmp_flag, 1'b0);
    check("R9", "irq cleared", cmp_irq, 1'b0);
  endtask

  task automatic t_at_over();
    wr_cfg(mk(1, 0, 1, 3'd5, 4'd0, 10'd300));
    push(3'd5, 10'd299, 0);
    check("R4", "299 not at-or-over 300", cmp_flag, 1'b0);
    push(3'd5, 10'd300, 0);
    check("R4", "300 at threshold sets", cmp_flag, 1'b1);
    clear_flag();
    push(3'd5, 10'd100, 0);
    check("R4", "100 not at-or-over", cmp_flag, 1'b0);
  endtask

  task automatic t_miss_restart();
    wr_cfg(mk(1, 0, 1, 3'd1, 4'd1, 10'd512));
    push(3'd1, 10'd600, 0);
    push(3'd1, 10'd100, 0);
    push(3'd1, 10'd700, 0);
    check("R6", "miss breaks run", cmp_flag, 1'b0);
    push(3'd1, 10'd800, 0);
    check("R6", "new run of two completes", cmp_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_other_channel();
    wr_cfg(mk(1, 0, 0, 3'd3, 4'd1, 10'd200));
    push(3'd3, 10'd5, 0);
    push(3'd4, 10'd999, 0);   // other channel, would be a miss
    push(3'd3, 10'd6, 0);
    check("R3", "other channel ignored", cmp_flag, 1'b1);
    clear_flag();
    wr_cfg(mk(0, 1, 0, 3'd3, 4'd0, 10'd200));
    push(3'd3, 10'd5, 0);
    push(3'd3, 10'd5, 0);
    check("R3", "disabled monitor ignores", cmp_flag, 1'b0);
    check("R3", "disabled monitor no irq", cmp_irq, 1'b0);
  endtask

  task automatic t_rewrite();
    wr_cfg(mk(1, 0, 0, 3'd0, 4'd1, 10'd50));
    push(3'd0, 10'd1, 0);
    wr_cfg(mk(1, 0, 0, 3'd0, 4'd1, 10'd50));
    push(3'd0, 10'd1, 0);
    check("R7", "rewrite restarts run", cmp_flag, 1'b0);
    push(3'd0, 10'd1, 0);
    check("R7", "run completes after rewrite", cmp_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_set_wins();
    wr_cfg(mk(1, 0, 0, 3'd0, 4'd0, 10'd50));
    push(3'd0, 10'd1, 1);
    check("R8", "set beats clear", cmp_flag, 1'b1);
    push(3'd0, 10'd60, 1);
    check("R8", "clear with a miss", cmp_flag, 1'b0);
  endtask

  task automatic t_irq_enable();
    wr_cfg(mk(1, 0, 1, 3'd7, 4'd0, 10'd1000));
    push(3'd7, 10'd1023, 0);
    check("R9", "flag without ie", cmp_flag, 1'b1);
    check("R9", "no irq without ie", cmp_irq, 1'b0);
    wr_cfg(mk(1, 1, 1, 3'd7, 4'd0, 10'd1000));
    check("R8", "flag survives rewrite", cmp_flag, 1'b1);
    check("R9", "irq follows new ie", cmp_irq, 1'b1);
    clear_flag();
  endtask

  task automatic t_longest_run();
    wr_cfg(mk(1, 0, 0, 3'd6, 4'd15, 10'd512));
    for (int i = 0; i < 15; i++) push(3'd6, 10'(i), 0);
    check("R5", "15 of 16", cmp_flag, 1'b0);
    push(3'd6, 10'd511, 0);
    check("R5", "16th sets flag", cmp_flag, 1'b1);
    clear_flag();
    push(3'd6, 10'd0, 0);
    check("R5", "counter restarted after set", cmp_flag, 1'b0);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_below();
    t_at_over();
    t_miss_restart();
    t_other_channel();
    t_rewrite();
    t_set_wins();
    t_irq_enable();
    t_longest_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule